// File: doc/BRIEF.md
# Double-Buffered Raster Scanout Controller

This block drives a 640x480 raster display from a pixel clock and arbitrates two external frame memories. Free-running horizontal and vertical counters produce active-low sync pulses and a blanking flag. In every frame one memory is the front buffer: the raster counters address it directly and its read word goes to the colour outputs. The other memory is the back buffer: its address, write data and write enable are passed through unchanged from a drawing engine.

The memory address is formed by joining the low bits of the line counter above the low bits of the pixel counter. Each row therefore takes a power-of-two stride and no multiplier is needed. A drawing engine raises a swap request when a frame is complete. The request is held until the raster enters vertical blanking. At that point the two buffers change roles and a one-cycle acknowledge is returned. The memories are modelled as synchronous ports with one cycle of read latency. Sync and blank are delayed by one register to line up with the returning pixel word.

Top module: `pingpong_scanout`

## Requirements
- R1: The pixel counter steps from 0 to H_TOTAL-1 and wraps. The line counter steps when the pixel counter wraps and runs from 0 to V_TOTAL-1. The default totals are 800 and 525. Counting starts on the third clock edge after rst_n is released.
- R2: hsync_n is low for pixel positions from H_ACTIVE+H_FP up to, but not including, H_ACTIVE+H_FP+H_SYNC. vsync_n is low for the matching line range. Each appears one cycle after the counter value it describes.
- R3: blank is high when the pixel position is at or beyond H_ACTIVE, or the line is at or beyond V_ACTIVE. It is delayed one cycle like the syncs.
- R4: The front buffer receives address {line[YW-1:0], pixel[XW-1:0]}, write enable low and write data zero, all in the same cycle as the counter.
- R5: The back buffer receives draw_addr, draw_wdata and draw_we combinationally. The front buffer is never written.
- R6: In the cycle after an address is presented, the outputs carry the front buffer's read word split as aux=[15:12], red=[11:8], green=[7:4], blue=[3:0]. All four fields are zero while blank is high.
- R7: A swap_req sampled high is held pending. On the clock edge where the counters move from the last pixel of line V_ACTIVE-1 into line V_ACTIVE, a pending request exchanges the front and back roles. The exchange never happens at any other time.
- R8: swap_done is high for exactly the one cycle that follows a serviced exchange. Several requests made before one service produce a single exchange. A request sampled on the servicing edge itself remains pending for the next frame.
- R9: While rst_n is low: hsync_n and vsync_n are 1, blank is 1, the colour fields are 0 and swap_done is 0. Memory 0 is the front buffer, and any pending request is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| swap_req | input | 1 | Drawing side asks for a buffer exchange |
| swap_done | output | 1 | One-cycle acknowledge of an exchange |
| draw_addr | input | XW+YW | Drawing engine word address |
| draw_wdata | input | 16 | Drawing engine write word |
| draw_we | input | 1 | Drawing engine write enable |
| m0_addr | output | XW+YW | Memory 0 address |
| m0_wdata | output | 16 | Memory 0 write data |
| m0_we | output | 1 | Memory 0 write enable |
| m0_rdata | input | 16 | Memory 0 read word, one cycle after address |
| m1_addr | output | XW+YW | Memory 1 address |
| m1_wdata | output | 16 | Memory 1 write data |
| m1_we | output | 1 | Memory 1 write enable |
| m1_rdata | input | 16 | Memory 1 read word, one cycle after address |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| blank | output | 1 | Blanking flag aligned with colour |
| red | output | 4 | Red field |
| green | output | 4 | Green field |
| blue | output | 4 | Blue field |
| aux | output | 4 | Special-purpose field |

## Verification
The hardest case to reach is a swap request that lands on the very clock edge that services an earlier pending request. It must neither be lost nor cause a second exchange in the same frame. The bench tracks the raster position in its reference model, waits until the model says the next edge is the servicing edge, and only then raises the second request. It then expects one acknowledge in each of the next two frames. A request abandoned by a mid-frame reset is checked the same way: a full frame must follow with no acknowledge and memory 0 still in front.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int PIX_W = 16;
  localparam int NUM_BUF = 2;

  typedef struct packed {
    logic hsync_act;
    logic vsync_act;
    logic blank;
  } scan_flags_t;
endpackage

// File: rtl/scan_timing.sv
module scan_timing
  import scan_pkg::*;
#(
  parameter int H_ACTIVE = 640,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BP     = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FP     = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 33,
  parameter int HCW      = 10,
  parameter int VCW      = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic [HCW-1:0] hcnt,
  output logic [VCW-1:0] vcnt,
  output scan_flags_t    flags,
  output logic           vblank_entry
);
  localparam int HT      = H_ACTIVE + H_FP + H_SYNC + H_BP;
  localparam int VT      = V_ACTIVE + V_FP + V_SYNC + V_BP;
  localparam int HS_BEG  = H_ACTIVE + H_FP;
  localparam int HS_END  = HS_BEG + H_SYNC;
  localparam int VS_BEG  = V_ACTIVE + V_FP;
  localparam int VS_END  = VS_BEG + V_SYNC;

  logic           h_last;
  logic           v_last;
  logic [HCW-1:0] h_nxt;
  logic [VCW-1:0] v_nxt;

  always_comb begin
    h_last = (hcnt == HCW'(HT - 1));
    v_last = (vcnt == VCW'(VT - 1));
    h_nxt  = h_last ? '0 : hcnt + 1'b1;
    if (h_last) v_nxt = v_last ? '0 : vcnt + 1'b1;
    else        v_nxt = vcnt;
  end

  always_comb begin
    flags.hsync_act = (32'(hcnt) >= HS_BEG) && (32'(hcnt) < HS_END);
    flags.vsync_act = (32'(vcnt) >= VS_BEG) && (32'(vcnt) < VS_END);
    flags.blank     = (32'(hcnt) >= H_ACTIVE) || (32'(vcnt) >= V_ACTIVE);
    vblank_entry    = h_last && (vcnt == VCW'(V_ACTIVE - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else begin
      hcnt <= h_nxt;
      vcnt <= v_nxt;
    end
  end

  // R1
  h_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt == HCW'(HT - 1)) |=> (hcnt == '0));

  // R1
  v_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt != HCW'(HT - 1)) |=> $stable(vcnt));
endmodule

// File: rtl/swap_ctrl.sv
module swap_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic swap_req,
  input  logic service,
  output logic disp_sel,
  output logic swap_done
);
  logic pending;
  logic fire;
  logic pend_nxt;
  logic sel_nxt;

  always_comb begin
    fire     = service && pending;
    pend_nxt = fire ? swap_req : (pending || swap_req);
    sel_nxt  = disp_sel ^ fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      disp_sel  <= 1'b0;
      swap_done <= 1'b0;
    end else begin
      pending   <= pend_nxt;
      disp_sel  <= sel_nxt;
      swap_done <= fire;
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_done |=> !swap_done);

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !service) |=> pending);

  // R7
  sel_at_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(disp_sel) |-> $past(service));
endmodule

// File: rtl/mem_route.sv
module mem_route
  import scan_pkg::*;
#(
  parameter int AW = 19
) (
  input  logic                             disp_sel,
  input  logic                             rd_sel,
  input  logic [AW-1:0]                    scan_addr,
  input  logic [AW-1:0]                    draw_addr,
  input  logic [PIX_W-1:0]                 draw_wdata,
  input  logic                             draw_we,
  input  logic [NUM_BUF-1:0][PIX_W-1:0]    buf_rdata,
  output logic [NUM_BUF-1:0][AW-1:0]       buf_addr,
  output logic [NUM_BUF-1:0][PIX_W-1:0]    buf_wdata,
  output logic [NUM_BUF-1:0]               buf_we,
  output logic [PIX_W-1:0]                 rd_word
);
  for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
    logic is_front;
    assign is_front     = (disp_sel == 1'(b));
    assign buf_addr[b]  = is_front ? scan_addr : draw_addr;
    assign buf_wdata[b] = is_front ? '0 : draw_wdata;
    assign buf_we[b]    = !is_front && draw_we;
  end

  assign rd_word = buf_rdata[rd_sel];
endmodule

// File: rtl/pixel_out.sv
module pixel_out
  import scan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  scan_flags_t       flags_in,
  input  logic              sel_in,
  input  logic [PIX_W-1:0]  rd_word,
  output logic              rd_sel,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic              blank,
  output logic [PIX_W-1:0]  pix
);
  scan_flags_t flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '{hsync_act: 1'b0, vsync_act: 1'b0, blank: 1'b1};
      rd_sel  <= 1'b0;
    end else begin
      flags_q <= flags_in;
      rd_sel  <= sel_in;
    end
  end

  always_comb begin
    hsync_n = !flags_q.hsync_act;
    vsync_n = !flags_q.vsync_act;
    blank   = flags_q.blank;
    pix     = flags_q.blank ? '0 : rd_word;
  end
endmodule

// File: rtl/pingpong_scanout.sv
module pingpong_scanout
  import scan_pkg::*;
#(
  parameter int H_ACTIVE = 640,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BP     = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FP     = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 33,
  parameter int XW       = 10,
  parameter int YW       = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               swap_req,
  output logic               swap_done,
  input  logic [XW+YW-1:0]   draw_addr,
  input  logic [15:0]        draw_wdata,
  input  logic               draw_we,
  output logic [XW+YW-1:0]   m0_addr,
  output logic [15:0]        m0_wdata,
  output logic               m0_we,
  input  logic [15:0]        m0_rdata,
  output logic [XW+YW-1:0]   m1_addr,
  output logic [15:0]        m1_wdata,
  output logic               m1_we,
  input  logic [15:0]        m1_rdata,
  output logic               hsync_n,
  output logic               vsync_n,
  output logic               blank,
  output logic [3:0]         red,
  output logic [3:0]         green,
  output logic [3:0]         blue,
  output logic [3:0]         aux
);
  localparam int HT  = H_ACTIVE + H_FP + H_SYNC + H_BP;
  localparam int VT  = V_ACTIVE + V_FP + V_SYNC + V_BP;
  localparam int HCW = $clog2(HT);
  localparam int VCW = $clog2(VT);
  localparam int AW  = XW + YW;

  logic [1:0]                        rst_pipe;
  logic                              core_rst_n;
  logic [HCW-1:0]                    hcnt;
  logic [VCW-1:0]                    vcnt;
  scan_flags_t                       flags;
  logic                              vblank_entry;
  logic                              disp_sel;
  logic                              rd_sel;
  logic [AW-1:0]                     scan_addr;
  logic [NUM_BUF-1:0][PIX_W-1:0]     buf_rdata;
  logic [NUM_BUF-1:0][AW-1:0]        buf_addr;
  logic [NUM_BUF-1:0][PIX_W-1:0]     buf_wdata;
  logic [NUM_BUF-1:0]                buf_we;
  logic [PIX_W-1:0]                  rd_word;
  logic [PIX_W-1:0]                  pix;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign core_rst_n = rst_pipe[1];

  scan_timing #(
    .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .HCW(HCW), .VCW(VCW)
  ) u_timing (
    .clk(clk), .rst_n(core_rst_n), .hcnt(hcnt), .vcnt(vcnt),
    .flags(flags), .vblank_entry(vblank_entry)
  );

  swap_ctrl u_swap (
    .clk(clk), .rst_n(core_rst_n), .swap_req(swap_req),
    .service(vblank_entry), .disp_sel(disp_sel), .swap_done(swap_done)
  );

  assign scan_addr    = {vcnt[YW-1:0], hcnt[XW-1:0]};
  assign buf_rdata[0] = m0_rdata;
  assign buf_rdata[1] = m1_rdata;

  mem_route #(.AW(AW)) u_route (
    .disp_sel(disp_sel), .rd_sel(rd_sel), .scan_addr(scan_addr),
    .draw_addr(draw_addr), .draw_wdata(draw_wdata), .draw_we(draw_we),
    .buf_rdata(buf_rdata), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .buf_we(buf_we), .rd_word(rd_word)
  );

  assign m0_addr  = buf_addr[0];
  assign m0_wdata = buf_wdata[0];
  assign m0_we    = buf_we[0];
  assign m1_addr  = buf_addr[1];
  assign m1_wdata = buf_wdata[1];
  assign m1_we    = buf_we[1];

  pixel_out u_pix (
    .clk(clk), .rst_n(core_rst_n), .flags_in(flags), .sel_in(disp_sel),
    .rd_word(rd_word), .rd_sel(rd_sel), .hsync_n(hsync_n),
    .vsync_n(vsync_n), .blank(blank), .pix(pix)
  );

  assign aux   = pix[15:12];
  assign red   = pix[11:8];
  assign green = pix[7:4];
  assign blue  = pix[3:0];

  // R1
  h_range_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    32'(hcnt) < HT);

  // R1
  v_range_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    32'(vcnt) < VT);

  // R3
  hs_in_blank_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    !hsync_n |-> blank);

  // R2
  vs_in_blank_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    !vsync_n |-> blank);

  // R5
  front0_no_write_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (disp_sel == 1'b0) |-> !m0_we);

  // R5
  front1_no_write_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (disp_sel == 1'b1) |-> !m1_we);
endmodule

// File: tb/sim_pingpong_scanout.sv
`timescale 1ns/1ps
module sim_pingpong_scanout;
  localparam int HA = 8, HFP = 2, HS = 3, HBP = 2;
  localparam int VA = 6, VFP = 1, VS = 2, VBP = 1;
  localparam int XW = 4, YW = 3;
  localparam int HT = HA + HFP + HS + HBP;
  localparam int VT = VA + VFP + VS + VBP;
  localparam int AW = XW + YW;
  localparam int NW = 1 << AW;
  localparam int FRAME = HT * VT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic swap_req = 1'b0;
  logic swap_done;
  logic [AW-1:0] draw_addr = '0;
  logic [15:0] draw_wdata = '0;
  logic draw_we = 1'b0;
  logic [AW-1:0] m0_addr, m1_addr;
  logic [15:0] m0_wdata, m1_wdata;
  logic m0_we, m1_we;
  logic [15:0] m0_rdata, m1_rdata;
  logic hsync_n, vsync_n, blank;
  logic [3:0] red, green, blue, aux;

  always #5 clk = ~clk;

  pingpong_scanout #(
    .H_ACTIVE(HA), .H_FP(HFP), .H_SYNC(HS), .H_BP(HBP),
    .V_ACTIVE(VA), .V_FP(VFP), .V_SYNC(VS), .V_BP(VBP),
    .XW(XW), .YW(YW)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .swap_req(swap_req), .swap_done(swap_done),
    .draw_addr(draw_addr), .draw_wdata(draw_wdata), .draw_we(draw_we),
    .m0_addr(m0_addr), .m0_wdata(m0_wdata), .m0_we(m0_we), .m0_rdata(m0_rdata),
    .m1_addr(m1_addr), .m1_wdata(m1_wdata), .m1_we(m1_we), .m1_rdata(m1_rdata),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .blank(blank),
    .red(red), .green(green), .blue(blue), .aux(aux)
  );

  // physical memories driven by the design's ports
  logic [15:0] pm0 [0:NW-1];
  logic [15:0] pm1 [0:NW-1];
  // logical contents kept by the reference model
  logic [15:0] sh0 [0:NW-1];
  logic [15:0] sh1 [0:NW-1];

  initial begin
    for (int i = 0; i < NW; i++) begin
      pm0[i] = '0; pm1[i] = '0; sh0[i] = '0; sh1[i] = '0;
    end
    m0_rdata = '0;
    m1_rdata = '0;
  end

  always @(posedge clk) begin
    if (m0_we) pm0[m0_addr] <= m0_wdata;
    if (m1_we) pm1[m1_addr] <= m1_wdata;
    m0_rdata <= pm0[m0_addr];
    m1_rdata <= pm1[m1_addr];
  end

  int nchk = 0;
  int nerr = 0;
  int cyc = 0;
  int done_seen = 0;
  bit run_chk = 1'b0;

  // reference model state
  int mx = 0, my = 0, sel = 0, pend = 0, rcnt = 0;
  logic e_hs = 1'b1, e_vs = 1'b1, e_bl = 1'b1, e_done = 1'b0;
  logic [15:0] e_pix = '0;

  function automatic int addr_of(int x, int y);
    return ((y % (1 << YW)) << XW) + (x % (1 << XW));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mx = 0; my = 0; sel = 0; pend = 0; rcnt = 0;
      e_hs = 1'b1; e_vs = 1'b1; e_bl = 1'b1; e_done = 1'b0; e_pix = '0;
    end else if (rcnt < 2) begin
      rcnt++;
      if (draw_we) begin
        if (sel == 0) sh1[draw_addr] = draw_wdata;
        else          sh0[draw_addr] = draw_wdata;
      end
    end else begin
      e_hs = !(mx >= HA + HFP && mx < HA + HFP + HS);
      e_vs = !(my >= VA + VFP && my < VA + VFP + VS);
      e_bl = (mx >= HA) || (my >= VA);
      if (e_bl) e_pix = '0;
      else e_pix = (sel == 0) ? sh0[addr_of(mx, my)] : sh1[addr_of(mx, my)];
      if (draw_we) begin
        if (sel == 0) sh1[draw_addr] = draw_wdata;
        else          sh0[draw_addr] = draw_wdata;
      end
      if (mx == HT - 1 && my == VA - 1 && pend != 0) begin
        e_done = 1'b1;
        sel = 1 - sel;
        pend = swap_req ? 1 : 0;
      end else begin
        e_done = 1'b0;
        if (swap_req) pend = 1;
      end
      if (mx == HT - 1) begin
        mx = 0;
        my = (my == VT - 1) ? 0 : my + 1;
      end else begin
        mx++;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (run_chk) begin
      if (!rst_n) begin
        chk("R9 hsync_n in reset", hsync_n, 1);
        chk("R9 vsync_n in reset", vsync_n, 1);
        chk("R9 blank in reset", blank, 1);
        chk("R9 colour in reset", {aux, red, green, blue}, 0);
        chk("R9 swap_done in reset", swap_done, 0);
      end else begin
        int cx, cy, fa, bk;
        cx = (rcnt < 2) ? 0 : mx;
        cy = (rcnt < 2) ? 0 : my;
        fa = addr_of(cx, cy);
        chk("R2 hsync_n", hsync_n, e_hs);
        chk("R2 vsync_n", vsync_n, e_vs);
        chk("R3 blank", blank, e_bl);
        chk("R6 colour word", {aux, red, green, blue}, e_pix);
        chk("R8 swap_done", swap_done, e_done);
        if (sel == 0) begin
          chk("R1 R4 R7 front address m0", m0_addr, fa);
          chk("R4 front we m0", m0_we, 0);
          chk("R5 back address m1", m1_addr, draw_addr);
          chk("R5 back we m1", m1_we, draw_we);
          if (draw_we) chk("R5 back data m1", m1_wdata, draw_wdata);
        end else begin
          chk("R1 R4 R7 front address m1", m1_addr, fa);
          chk("R4 front we m1", m1_we, 0);
          chk("R5 back address m0", m0_addr, draw_addr);
          chk("R5 back we m0", m0_we, draw_we);
          if (draw_we) chk("R5 back data m0", m0_wdata, draw_wdata);
        end
        bk = 0;
        if (swap_done) done_seen++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nerr++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic fill(input int tag);
    for (int a = 0; a < NW; a++) begin
      @(negedge clk); #1;
      draw_addr = AW'(a);
      draw_wdata = 16'((tag << 12) ^ (a * 37) ^ (tag * 401));
      draw_we = 1'b1;
    end
    @(negedge clk); #1;
    draw_we = 1'b0;
  endtask

  task automatic pulse_req();
    @(negedge clk); #1;
    swap_req = 1'b1;
    @(negedge clk); #1;
    swap_req = 1'b0;
  endtask

  initial begin
    int base;
    run_chk = 1'b1;
    step(4);
    // R9: reset values held while rst_n is low
    chk("R9 blank during reset", blank, 1);
    chk("R9 sync during reset", {hsync_n, vsync_n}, 2'b11);
    rst_n = 1'b1;
    step(2);
    // R1: counting has not yet started, front address still origin
    chk("R1 held two cycles after release", m0_addr, 0);
    step(FRAME);

    // R5 R6 R7: draw into back buffer, exchange, see it displayed
    fill(3);
    base = done_seen;
    pulse_req();
    step(2 * FRAME);
    chk("R8 single acknowledge for one request", done_seen - base, 1);

    // R8: two requests before one service merge into one exchange
    fill(5);
    base = done_seen;
    pulse_req();
    step(3);
    pulse_req();
    step(2 * FRAME);
    chk("R8 merged requests give one exchange", done_seen - base, 1);

    // R8: request on the servicing edge stays pending one more frame
    base = done_seen;
    pulse_req();
    while (!(mx == HT - 1 && my == VA - 1 && rcnt >= 2)) @(negedge clk);
    #1 swap_req = 1'b1;
    @(negedge clk); #1 swap_req = 1'b0;
    chk("R8 first service at boundary", done_seen - base, 1);
    step(FRAME + 2);
    chk("R8 boundary request serviced next frame", done_seen - base, 2);

    // R9: pending request discarded by reset
    base = done_seen;
    pulse_req();
    step(3);
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(2 * FRAME);
    chk("R9 pending request cleared by reset", done_seen - base, 0);
    chk("R9 memory 0 in front after reset", m0_we, 0);

    // R6: draw again after reset and exchange with new data
    fill(9);
    pulse_req();
    step(2 * FRAME);

    run_chk = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule